// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives a three-phase inverter bridge. It produces three pairs of PWM outputs, one pair per phase. In each pair, the normal-phase pin and the counter-phase pin are never active together. The gap between them (the dead time) is set in hardware. Two counters sweep up and down together in a triangle. The primary counter starts the sweep offset by the dead-time value `p`. The secondary counter starts at zero. The two counters therefore stay exactly `p` counts apart for the whole sweep.

Each phase compares its duty value `n` against both counters:
- The secondary counter sets the normal-phase pulse, which is centred on the crest of the sweep.
- The primary counter sets the counter-phase pulse, which is centred on the trough.

The two counters only advance on clocks where the `tick` count-enable is high.

The `run` input starts and stops counting. A rising edge on `run` reloads the sweep and captures the period and the duty values. A low `run` freezes the sweep. Several other features are available:
- Each output pin can use either polarity.
- Each output can have a chosen idle level before the first start.
- A cutoff input forces all six pins inactive.
- Each duty input goes through a shadow register. The duty value reaches the comparators only at a turnaround of the sweep, either the crest or the trough.

Legal settings are `1 <= p <= n`, `n + p <= m` and `m + 1 < 2^W`.

Top module: `tri_pwm`

## Requirements
- R1: After reset and before the first start, every normal-phase pin shows `init_n XNOR pol_n`. Every counter-phase pin shows `init_c XNOR pol_c`. `half_tgl` is 0 and no interrupt flag is raised.
- R2: `half_tgl` is 0 at start. It flips each time the primary counter arrives one count above the period value, and on each secondary-counter underflow. Each level lasts `m + 2 - p` ticks, so the full period is `2(m + 2 - p)` ticks for any tick spacing.
- R3: With the active level high, each normal-phase pin is active for `2(m - n - p + 1)` consecutive ticks per period.
- R4: Each counter-phase pin is active for `2(n + 1 - p)` consecutive ticks per period.
- R5: Within a pair, the normal-phase and counter-phase outputs are never active in the same cycle while running.
- R6: The period value `m` and the dead time `p` are captured on the start edge. Changing the `period` input while running leaves the sweep unchanged.
- R7: While `run` is low, every PWM pin and `half_tgl` hold their level, provided polarity, idle level and cutoff are unchanged.
- R8: While `cutoff` is 1, every normal-phase pin equals `NOT pol_n` and every counter-phase pin equals `NOT pol_c`, in the same cycle.
- R9: `pol_n`/`pol_c` = 1 selects an active-high pin and 0 selects an active-low pin. Pulse widths do not change with polarity.
- R10: Duty inputs are copied to the comparators at the start edge, and otherwise only on the crest turnaround tick (`load_crest` = 1) or on the underflow tick (`load_crest` = 0). A pulse that straddles the load point uses the old value on one side and the new value on the other.
- R11: `irq_cmp[i]` is high on each tick where either counter equals phase i's active duty value, which gives 4 pulses per period. `irq_unf` is high on the tick where the secondary counter passes below zero, which gives 1 pulse per period. Neither flag is raised while `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; counters advance on clocks where it is 1 |
| run | input | 1 | 1 = counting; rising edge restarts the sweep |
| period | input | W | Period value m, captured at start |
| dead | input | W | Dead time p, loaded into the primary counter at start |
| duty | input | PH×W | Duty value n per phase (shadow inputs) |
| load_crest | input | 1 | 1 = copy duty at the crest, 0 = at the trough |
| pol_n | input | 1 | Normal-phase active level (1 = high) |
| pol_c | input | 1 | Counter-phase active level (1 = high) |
| init_n | input | 1 | Normal-phase activity before the first start |
| init_c | input | 1 | Counter-phase activity before the first start |
| cutoff | input | 1 | Forces all PWM pins inactive |
| pwm_n | output | PH | Normal-phase pins |
| pwm_c | output | PH | Counter-phase pins |
| half_tgl | output | 1 | Toggles every half period |
| irq_cmp | output | PH | Per-phase compare-match flags |
| irq_unf | output | 1 | Secondary-counter underflow flag |

## Verification
The bench targets duty values that straddle a turnaround: it rewrites a duty value during the crest state and during the trough state.
- If the comparators were not double-buffered, the straddling pulse would shrink or stretch by the wrong amount.
- If the load happened at the wrong turnaround, the width change would show up on the other pin of the pair.

The bench also targets the crest and the trough themselves:
- A crest that turned at `m` instead of `m + 1` would shorten each half period by one tick.
- A design that let the wrapped secondary counter compare as a large value would light the normal-phase pin at the trough.

Finally, the bench runs the sweep with a sparse tick. It also changes the period input mid-run and stops the sweep mid-pulse, to expose a period that is not latched or outputs that drift after a stop.

// File: rtl/tri_pwm.sv
module tri_pwm #(
  parameter int W  = 16,
  parameter int PH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  run,
  input  logic [W-1:0]          period,
  input  logic [W-1:0]          dead,
  input  logic [PH-1:0][W-1:0]  duty,
  input  logic                  load_crest,
  input  logic                  pol_n,
  input  logic                  pol_c,
  input  logic                  init_n,
  input  logic                  init_c,
  input  logic                  cutoff,
  output logic [PH-1:0]         pwm_n,
  output logic [PH-1:0]         pwm_c,
  output logic                  half_tgl,
  output logic [PH-1:0]         irq_cmp,
  output logic                  irq_unf
);

  logic                 run_q, armed, up;
  logic [W-1:0]         c0, c1, per_q;
  logic [PH-1:0][W-1:0] cmp;

  wire         start   = run & ~run_q;
  wire         adv     = run & run_q & tick;
  wire [W:0]   top_val = {1'b0, per_q} + 1'b1;
  wire         at_top  = up & (c0 == per_q);
  wire         crest   = up & ({1'b0, c0} == top_val);
  wire         trough  = ~up & (c1 == '0);
  wire         reload  = (crest & load_crest) | (trough & ~load_crest);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      armed    <= 1'b0;
      up       <= 1'b1;
      c0       <= '0;
      c1       <= '0;
      per_q    <= '0;
      cmp      <= '0;
      half_tgl <= 1'b0;
    end else begin
      run_q <= run;
      if (start) begin
        armed    <= 1'b1;
        up       <= 1'b1;
        c0       <= dead;
        c1       <= '0;
        per_q    <= period;
        cmp      <= duty;
        half_tgl <= 1'b0;
      end else if (adv) begin
        if (up && !crest) begin
          c0 <= c0 + 1'b1;
          c1 <= c1 + 1'b1;
        end else begin
          c0 <= c0 - 1'b1;
          c1 <= c1 - 1'b1;
        end
        if (crest)  up <= 1'b0;
        if (trough) up <= 1'b1;
        if (reload) cmp <= duty;
        if (at_top || trough) half_tgl <= ~half_tgl;
      end
    end
  end

  assign irq_unf = adv & trough;

  for (genvar i = 0; i < PH; i++) begin : g_phase
    logic act_n, act_c;
    assign act_n = armed ? (up ? (c1 > cmp[i] && c1 != '1) : (c1 >= cmp[i])) : init_n;
    assign act_c = armed ? (up ? (c0 <= cmp[i]) : (c0 < cmp[i])) : init_c;
    assign pwm_n[i]   = cutoff ? ~pol_n : (act_n ~^ pol_n);
    assign pwm_c[i]   = cutoff ? ~pol_c : (act_c ~^ pol_c);
    assign irq_cmp[i] = adv & ((c0 == cmp[i]) | (c1 == cmp[i]));
  end

endmodule

// File: rtl/tri_pwm_chk.sv
module tri_pwm_chk #(
  parameter int PH = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          cutoff,
  input logic          pol_n,
  input logic          pol_c,
  input logic          init_n,
  input logic          init_c,
  input logic [PH-1:0] pwm_n,
  input logic [PH-1:0] pwm_c,
  input logic          half_tgl,
  input logic [PH-1:0] irq_cmp,
  input logic          irq_unf
);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ((({PH{pol_n}} ~^ pwm_n) & ({PH{pol_c}} ~^ pwm_c)) == '0));

  assert_cutoff_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cutoff |-> (pwm_n == {PH{~pol_n}} && pwm_c == {PH{~pol_c}}));

  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run) && $stable({pol_n, pol_c, cutoff, init_n, init_c}))
      |-> ($stable(pwm_n) && $stable(pwm_c) && $stable(half_tgl)));

  assert_unf_flips_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_unf |=> (half_tgl != $past(half_tgl)));

  assert_quiet_when_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (irq_cmp == '0 && !irq_unf));

endmodule

bind tri_pwm tri_pwm_chk #(.PH(PH)) chk (.*);

// File: tb/tri_pwm_test.sv
`timescale 1ns/1ps
module tri_pwm_test;
  localparam int W = 16;
  localparam int PH = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, run, load_crest, pol_n, pol_c, init_n, init_c, cutoff;
  logic tick = 1'b1;
  logic [W-1:0] period, dead;
  logic [PH-1:0][W-1:0] duty;
  logic [PH-1:0] pwm_n, pwm_c, irq_cmp;
  logic half_tgl, irq_unf;

  tri_pwm #(.W(W), .PH(PH)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .period(period), .dead(dead),
    .duty(duty), .load_crest(load_crest), .pol_n(pol_n), .pol_c(pol_c),
    .init_n(init_n), .init_c(init_c), .cutoff(cutoff), .pwm_n(pwm_n), .pwm_c(pwm_c),
    .half_tgl(half_tgl), .irq_cmp(irq_cmp), .irq_unf(irq_unf));

  int checks = 0, errors = 0;
  bit finished = 0;
  bit sparse = 0;

  always @(negedge clk) tick <= sparse ? ~tick : 1'b1;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  typedef struct { int exp; string tag; } item_t;
  item_t q[$];
  bit meas_en = 0, inv = 0, m_armed = 0;
  int sel = 0, run_len = 0;

  function automatic logic pick(int s);
    case (s)
      0: return pwm_n[0];
      1: return pwm_n[1];
      2: return pwm_n[2];
      3: return pwm_c[0];
      4: return pwm_c[1];
      5: return pwm_c[2];
      default: return half_tgl;
    endcase
  endfunction

  always @(negedge clk) begin
    logic s;
    item_t it;
    s = pick(sel) ^ inv;
    if (!meas_en) begin
      m_armed = 0;
      run_len = 0;
    end else if (!s) begin
      if (m_armed && run_len > 0 && q.size() > 0) begin
        it = q.pop_front();
        check(run_len == it.exp, it.tag, run_len, it.exp);
      end
      m_armed = 1;
      run_len = 0;
    end else if (m_armed) begin
      run_len++;
    end
  end

  int n_cmp0 = 0, n_cmp2 = 0, n_unf = 0, n_overlap = 0;
  always @(negedge clk) begin
    if (irq_cmp[0]) n_cmp0++;
    if (irq_cmp[2]) n_cmp2++;
    if (irq_unf) n_unf++;
    if (rst_n && !cutoff && ((({PH{pol_n}} ~^ pwm_n) & ({PH{pol_c}} ~^ pwm_c)) != '0)) n_overlap++;
  end

  task automatic expect_w(int v, string tag);
    q.push_back('{v, tag});
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic drain(string tag);
    int t = 0;
    while (q.size() != 0 && t < 3000) begin
      step();
      t++;
    end
    if (q.size() != 0) begin
      check(0, tag, q.size(), 0);
      q.delete();
    end
    meas_en = 0;
    step();
  endtask

  task automatic wait_tgl(bit rising);
    bit prev = half_tgl;
    forever begin
      step();
      if (rising ? (!prev && half_tgl) : (prev && !half_tgl)) break;
      prev = half_tgl;
    end
  endtask

  task automatic measure(int s, bit iv, int v, int cnt, string tag);
    sel = s;
    inv = iv;
    meas_en = 1;
    for (int k = 0; k < cnt; k++) expect_w(v, tag);
    drain(tag);
  endtask

  initial begin
    int c0s, c2s, us;
    logic [PH-1:0] hn, hc;
    logic ht;
    rst_n = 0; run = 0; period = 16'd20; dead = 16'd3;
    duty[0] = 16'd8; duty[1] = 16'd5; duty[2] = 16'd14;
    load_crest = 1; pol_n = 1; pol_c = 1; init_n = 1; init_c = 0; cutoff = 0;
    repeat (5) step();
    rst_n = 1;
    repeat (3) step();
    // R1 idle levels
    check(pwm_n == 3'b111, "R1 normal idle", pwm_n, 7);
    check(pwm_c == 3'b000, "R1 counter idle", pwm_c, 0);
    check(half_tgl == 1'b0, "R1 half toggle", half_tgl, 0);
    check(irq_cmp == 3'b000, "R1 irq_cmp", irq_cmp, 0);
    check(irq_unf == 1'b0, "R1 irq_unf", irq_unf, 0);

    run = 1;
    repeat (2) step();
    period = 16'd50; // R6: must not affect the running sweep
    measure(6, 0, 19, 3, "R2/R6 half period");
    measure(0, 0, 20, 2, "R3 normal phase0");
    measure(1, 0, 26, 2, "R3 normal phase1");
    measure(2, 0, 8, 2, "R3 normal phase2");
    measure(3, 0, 12, 2, "R4 counter phase0");
    measure(4, 0, 6, 2, "R4 counter phase1");
    measure(5, 0, 24, 2, "R4 counter phase2");

    // R11 flag counts over one period
    wait_tgl(1);
    c0s = n_cmp0; c2s = n_cmp2; us = n_unf;
    wait_tgl(1);
    check(n_cmp0 - c0s == 4, "R11 irq_cmp0 per period", n_cmp0 - c0s, 4);
    check(n_cmp2 - c2s == 4, "R11 irq_cmp2 per period", n_cmp2 - c2s, 4);
    check(n_unf - us == 1, "R11 irq_unf per period", n_unf - us, 1);

    // R10 crest load: straddling normal pulse mixes 8 then 12
    sel = 0; inv = 0;
    wait_tgl(0);
    meas_en = 1;
    expect_w(20, "R10 crest old");
    wait_tgl(1); wait_tgl(0); wait_tgl(1);
    duty[0] = 16'd12;
    expect_w(16, "R10 crest mixed");
    expect_w(12, "R10 crest new");
    drain("R10 crest");

    // R10 trough load: straddling counter pulse mixes 12 then 8
    load_crest = 0;
    sel = 3;
    wait_tgl(1);
    meas_en = 1;
    expect_w(20, "R10 trough old");
    wait_tgl(0); wait_tgl(1);
    duty[0] = 16'd8;
    expect_w(16, "R10 trough mixed");
    expect_w(12, "R10 trough new");
    drain("R10 trough");

    // R9 active-low normal phase
    pol_n = 0;
    measure(0, 1, 20, 2, "R9 active-low width");
    cutoff = 1;
    step();
    check(pwm_n == 3'b111, "R8 cutoff normal", pwm_n, 7);
    check(pwm_c == 3'b000, "R8 cutoff counter", pwm_c, 0);
    cutoff = 0;
    pol_n = 1;
    step();

    // R2 with a sparse tick
    sparse = 1;
    measure(6, 0, 38, 2, "R2 sparse half period");
    sparse = 0;

    // R7 stop mid-sweep
    wait_tgl(1);
    repeat (3) step();
    run = 0;
    step();
    hn = pwm_n; hc = pwm_c; ht = half_tgl;
    duty[0] = 16'd3;
    repeat (20) step();
    check(pwm_n == hn, "R7 normal held", pwm_n, hn);
    check(pwm_c == hc, "R7 counter held", pwm_c, hc);
    check(half_tgl == ht, "R7 half held", half_tgl, ht);
    check(irq_cmp == 3'b000 && !irq_unf, "R11 quiet when stopped", {irq_cmp, irq_unf}, 0);

    check(n_overlap == 0, "R5 pair overlap cycles", n_overlap, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule